// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block is one DMA channel that software drives through four memory-mapped registers: a transfer address, a transfer count, a 16-bit command word and a read-only status word. A command write that carries both the go bit and the enable bit arms the channel. The armed channel then moves a block of data between a peripheral and a single-cycle memory bus. The unit of transfer is a byte, a 16-bit word or a 32-bit longword.

Each transfer follows the same steps. The channel waits for the peripheral's request. It then issues one memory cycle and gives the peripheral a one-cycle acknowledge. After that it advances the address by the unit size and counts down. Software loads the count as the number of transfers minus one.

The run stops in one of three ways:
- The last transfer completes.
- A start address is not aligned to the unit size, and the start is refused.
- A memory cycle returns a bus error.

A completed run and a bus error both raise an interrupt. Software clears the interrupt by reading the address register.

Top module: `dmac_channel`

## Requirements
- R1: After reset, the status register reads 0, `irq`, `mem_req` and `dev_ack` are low, and the command register reads 0.
- R2: A count value of N-1 produces exactly N memory cycles. A count of 0 produces one. Once the run has stopped, a held `dev_req` causes no further memory cycle.
- R3: The unit size is chosen by command bits. Bit 8 set selects longword, `mem_size`=2, step 4, even when bit 1 is also set. Otherwise bit 1 set selects word, `mem_size`=1, step 2. With neither bit set the unit is a byte, `mem_size`=0, step 1. Transfer k (counting from 0) uses address start+k·step, and the address register ends at start+N·step.
- R4: Command bit 2 set moves data from memory to the device: `mem_we`=0, and `dev_wdata` holds `mem_rdata` from that cycle while `dev_ack` is high. Bit 2 clear moves data from the device to memory: `mem_we`=1 and `mem_wdata` equals `dev_rdata`.
- R5: A command write arms the channel only when bit 15 (go) and bit 0 (enable) are both set. A write with either bit missing leaves status at 0, and no memory cycle follows a device request.
- R6: When the last transfer completes, the armed bit clears and `irq` rises. The status register then reads 0x42: interrupt (bit 1) and count-wrap (bit 6). The count register reads all ones.
- R7: A read of the address register (index 0) clears the interrupt bit and `irq`. If a completion or a bus error sets the interrupt in the same cycle, the set wins.
- R8: A start whose address is not a multiple of the unit size is refused. Status reads 0x28, alignment (bit 5) plus halted (bit 3). No memory cycle is issued.
- R9: A bus error on a memory cycle stops the channel without an acknowledge. Status reads 0x1A: interrupt, halted, bus error (bit 4). `irq` is high, and the address register keeps the failing address.
- R10: A memory cycle begins only after `dev_req`, lasts one cycle, and is followed in the next cycle by a one-cycle `dev_ack`. Only one transfer is ever in flight.
- R11: Command bit 3 and bits 6:4 are stored and read back. `irq_level` equals field 6:4 plus 3, so the value 0x0058 gives level 8 and a field of 0 gives level 3.
- R12: While armed, status bit 2 (accessed) is set, so status reads 0x05. Writes to the address, count and command registers are ignored. Writes to the status register (index 3) are always ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Register access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | Register index: 0 address, 1 count, 2 command, 3 status |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data for the selected register (combinational) |
| dev_req | input | 1 | Peripheral requests a transfer |
| dev_ack | output | 1 | One-cycle acknowledge that closes a transfer |
| dev_rdata | input | 32 | Data from the peripheral |
| dev_wdata | output | 32 | Data to the peripheral |
| mem_req | output | 1 | Memory cycle strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_size | output | 2 | Unit size: 0 byte, 1 word, 2 longword |
| mem_wdata | output | 32 | Write data to memory |
| mem_rdata | input | 32 | Read data from memory, same cycle |
| mem_berr | input | 1 | Bus error response, same cycle |
| irq | output | 1 | Interrupt request |
| irq_level | output | 4 | Programmed interrupt level |

## Verification
The interrupt set by the final transfer and the clear caused by reading the address register can land on the same clock edge. The bench provokes this by raising the address read in the very cycle in which it sees `dev_ack` for the last transfer. It then judges that `irq` is still high and that status still shows the interrupt bit, because a new event must not be lost to an old acknowledgement. A later plain read of the address register must then clear it.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam logic [1:0] REG_ADDR  = 2'd0;
    localparam logic [1:0] REG_COUNT = 2'd1;
    localparam logic [1:0] REG_CMD   = 2'd2;
    localparam logic [1:0] REG_STAT  = 2'd3;

    localparam int C_EN   = 0;
    localparam int C_WORD = 1;
    localparam int C_DIR  = 2;
    localparam int C_LONG = 8;
    localparam int C_GO   = 15;

    // bits retained in the command register (go is a strobe, not stored)
    localparam logic [15:0] CMD_KEEP = 16'h017F;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_BUS,
        ST_ACK
    } seq_e;

    // packed MSB first: armed lands on bit 0
    typedef struct packed {
        logic wrap;
        logic align;
        logic berr;
        logic halt;
        logic acc;
        logic intr;
        logic armed;
    } stat_t;

    typedef struct packed {
        logic start_ok;
        logic start_bad;
        logic step;
        logic last;
        logic berr;
    } evt_t;

    function automatic size_e size_of(input logic [15:0] cmd);
        if (cmd[C_LONG])      return SZ_LONG;
        else if (cmd[C_WORD]) return SZ_WORD;
        else                  return SZ_BYTE;
    endfunction

    function automatic logic [2:0] step_of(input size_e s);
        case (s)
            SZ_LONG: return 3'd4;
            SZ_WORD: return 3'd2;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic aligned(input logic [1:0] low, input size_e s);
        case (s)
            SZ_LONG: return (low == 2'b00);
            SZ_WORD: return (low[0] == 1'b0);
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/dmac_counters.sv
module dmac_counters #(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_addr_en,
    input  logic          wr_cnt_en,
    input  logic [AW-1:0] wdata_a,
    input  logic [CW-1:0] wdata_c,
    input  logic          step_en,
    input  logic [2:0]    step,
    output logic [AW-1:0] addr_q,
    output logic [CW-1:0] cnt_q,
    output logic          cnt_zero
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (wr_addr_en) begin
            addr_q <= wdata_a;
        end else if (step_en) begin
            addr_q <= addr_q + AW'(step);
        end
    end

    // decrement past zero wraps to all ones, which software sees after a run
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_cnt_en) begin
            cnt_q <= wdata_c;
        end else if (step_en) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic aligned_ok,
    input  logic dev_req,
    input  logic mem_berr,
    input  logic cnt_zero,
    output seq_e state,
    output logic mem_req,
    output logic dev_ack,
    output evt_t evt
);

    seq_e nxt;

    always_comb begin
        nxt = state;
        evt = '0;
        case (state)
            ST_IDLE: begin
                if (go) begin
                    if (aligned_ok) begin
                        evt.start_ok = 1'b1;
                        nxt          = ST_WAIT;
                    end else begin
                        evt.start_bad = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (dev_req) nxt = ST_BUS;
            end
            ST_BUS: begin
                if (mem_berr) begin
                    evt.berr = 1'b1;
                    nxt      = ST_IDLE;
                end else begin
                    nxt = ST_ACK;
                end
            end
            ST_ACK: begin
                evt.step = 1'b1;
                if (cnt_zero) begin
                    evt.last = 1'b1;
                    nxt      = ST_IDLE;
                end else begin
                    nxt = ST_WAIT;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign mem_req = (state == ST_BUS);
    assign dev_ack = (state == ST_ACK);

endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_sel,
    input  logic          cpu_wr,
    input  logic [1:0]    cpu_idx,
    input  logic [15:0]   wdata_lo,
    input  evt_t          evt,
    input  logic          busy,
    input  logic [AW-1:0] addr_q,
    input  logic [CW-1:0] cnt_q,
    output logic [15:0]   cmd_q,
    output stat_t         stat,
    output logic [31:0]   rdata,
    output logic          wr_addr_en,
    output logic          wr_cnt_en,
    output logic          go
);

    stat_t stat_q;
    stat_t stat_n;
    logic  wr_ok;
    logic  rd_addr;
    logic  wr_cmd;

    always_comb begin
        wr_ok      = cpu_sel && cpu_wr && !stat_q.armed;
        wr_addr_en = wr_ok && (cpu_idx == REG_ADDR);
        wr_cnt_en  = wr_ok && (cpu_idx == REG_COUNT);
        wr_cmd     = wr_ok && (cpu_idx == REG_CMD);
        go         = wr_cmd && wdata_lo[C_GO] && wdata_lo[C_EN];
        rd_addr    = cpu_sel && !cpu_wr && (cpu_idx == REG_ADDR);
    end

    always_ff @(posedge clk) begin
        if (rst)         cmd_q <= '0;
        else if (wr_cmd) cmd_q <= wdata_lo & CMD_KEEP;
    end

    // later lines win: events that set the interrupt override the read-clear
    always_comb begin
        stat_n     = stat_q;
        stat_n.acc = 1'b0;
        if (rd_addr) stat_n.intr = 1'b0;
        if (evt.start_ok) begin
            stat_n       = '0;
            stat_n.armed = 1'b1;
        end
        if (evt.start_bad) begin
            stat_n.align = 1'b1;
            stat_n.halt  = 1'b1;
            stat_n.berr  = 1'b0;
            stat_n.wrap  = 1'b0;
        end
        if (evt.berr) begin
            stat_n.armed = 1'b0;
            stat_n.berr  = 1'b1;
            stat_n.halt  = 1'b1;
            stat_n.intr  = 1'b1;
        end
        if (evt.last) begin
            stat_n.armed = 1'b0;
            stat_n.intr  = 1'b1;
            stat_n.wrap  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_n;
    end

    always_comb begin
        stat     = stat_q;
        stat.acc = busy;
    end

    always_comb begin
        case (cpu_idx)
            REG_ADDR:  rdata = 32'(addr_q);
            REG_COUNT: rdata = 32'(cnt_q);
            REG_CMD:   rdata = {16'h0000, cmd_q};
            default:   rdata = {25'h0, stat};
        endcase
    end

endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter bit SHORT_COUNT = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_sel,
    input  logic          cpu_wr,
    input  logic [1:0]    cpu_addr,
    input  logic [31:0]   cpu_wdata,
    output logic [31:0]   cpu_rdata,
    input  logic          dev_req,
    output logic          dev_ack,
    input  logic [DW-1:0] dev_rdata,
    output logic [DW-1:0] dev_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_berr,
    output logic          irq,
    output logic [3:0]    irq_level
);

    localparam int CW = SHORT_COUNT ? 16 : 32;

    logic [15:0]   cmd_q;
    stat_t         stat;
    evt_t          evt;
    seq_e          state;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic          cnt_zero;
    logic          wr_addr_en;
    logic          wr_cnt_en;
    logic          go;
    logic          aligned_ok;
    size_e         run_size;
    logic          sts_armed;
    logic          sts_align;

    // the size for the alignment test comes from the command being written
    assign aligned_ok = aligned(addr_q[1:0], size_of(cpu_wdata[15:0]));
    assign run_size   = size_of(cmd_q);

    dmac_regfile #(.AW(AW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cpu_sel    (cpu_sel),
        .cpu_wr     (cpu_wr),
        .cpu_idx    (cpu_addr),
        .wdata_lo   (cpu_wdata[15:0]),
        .evt        (evt),
        .busy       (state != ST_IDLE),
        .addr_q     (addr_q),
        .cnt_q      (cnt_q),
        .cmd_q      (cmd_q),
        .stat       (stat),
        .rdata      (cpu_rdata),
        .wr_addr_en (wr_addr_en),
        .wr_cnt_en  (wr_cnt_en),
        .go         (go)
    );

    dmac_counters #(.AW(AW), .CW(CW)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .wr_addr_en (wr_addr_en),
        .wr_cnt_en  (wr_cnt_en),
        .wdata_a    (cpu_wdata[AW-1:0]),
        .wdata_c    (cpu_wdata[CW-1:0]),
        .step_en    (evt.step),
        .step       (step_of(run_size)),
        .addr_q     (addr_q),
        .cnt_q      (cnt_q),
        .cnt_zero   (cnt_zero)
    );

    dmac_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .aligned_ok (aligned_ok),
        .dev_req    (dev_req),
        .mem_berr   (mem_berr),
        .cnt_zero   (cnt_zero),
        .state      (state),
        .mem_req    (mem_req),
        .dev_ack    (dev_ack),
        .evt        (evt)
    );

    // memory-to-device data is held for the peripheral through the ack cycle
    always_ff @(posedge clk) begin
        if (rst)
            dev_wdata <= '0;
        else if (mem_req && !mem_berr && cmd_q[C_DIR])
            dev_wdata <= mem_rdata;
    end

    assign mem_addr  = addr_q;
    assign mem_we    = !cmd_q[C_DIR];
    assign mem_size  = run_size;
    assign mem_wdata = dev_rdata;
    assign irq       = stat.intr;
    assign irq_level = 4'(cmd_q[6:4]) + 4'd3;
    assign sts_armed = stat.armed;
    assign sts_align = stat.align;

endmodule

// File: rtl/dmac_chk.sv
module dmac_chk (
    input logic       clk,
    input logic       rst,
    input logic       cpu_sel,
    input logic       cpu_wr,
    input logic [1:0] cpu_addr,
    input logic       mem_req,
    input logic       mem_berr,
    input logic       dev_ack,
    input logic       irq,
    input logic       armed,
    input logic       align
);

    assert_bus_then_ack_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_berr |=> dev_ack && !mem_req);

    assert_ack_single_R10: assert property (@(posedge clk) disable iff (rst)
        dev_ack |=> !dev_ack);

    assert_req_needs_armed_R8: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> armed);

    assert_misalign_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        align |-> !mem_req && !armed);

    assert_berr_stop_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_berr |=> !armed && irq && !dev_ack);

    assert_stop_raises_irq_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(armed) |-> irq);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_sel && !cpu_wr && cpu_addr == 2'd0 && !mem_req && !dev_ack |=> !irq);

endmodule

bind dmac_channel dmac_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_sel  (cpu_sel),
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .mem_req  (mem_req),
    .mem_berr (mem_berr),
    .dev_ack  (dev_ack),
    .irq      (irq),
    .armed    (sts_armed),
    .align    (sts_align)
);

// File: tb/sim_dmac_channel.sv
module sim_dmac_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_sel = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [1:0]  cpu_addr = 2'd0;
    logic [31:0] cpu_wdata = 32'h0;
    logic [31:0] cpu_rdata;
    logic        dev_req = 1'b0;
    logic        dev_ack;
    logic [31:0] dev_rdata = 32'h0;
    logic [31:0] dev_wdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_berr;
    logic        irq;
    logic [3:0]  irq_level;
    logic [31:0] bad_addr = 32'hFFFF_FFF0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic        s_seen, s_we, s_ack;
    logic [31:0] s_addr, s_wd, s_dw;
    logic [1:0]  s_size;

    always #2 clk = ~clk;

    // single-cycle memory model
    assign mem_rdata = mem_addr ^ 32'h5A5A_0000;
    assign mem_berr  = mem_req && (mem_addr == bad_addr);

    dmac_channel u0 (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .dev_req(dev_req), .dev_ack(dev_ack), .dev_rdata(dev_rdata),
        .dev_wdata(dev_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_berr(mem_berr), .irq(irq),
        .irq_level(irq_level)
    );

    // {unit select[1:0] (bit0 -> cmd bit1, bit1 -> cmd bit8), dir, start, transfers, step}
    localparam logic [45:0] VEC [6] = '{
        {2'd0, 1'b0, 32'h0000_1000, 8'd1, 3'd1},
        {2'd0, 1'b1, 32'h0000_1003, 8'd3, 3'd1},
        {2'd1, 1'b0, 32'h0000_2002, 8'd4, 3'd2},
        {2'd2, 1'b1, 32'h0000_3004, 8'd2, 3'd4},
        {2'd3, 1'b0, 32'h0000_4008, 8'd3, 3'd4},
        {2'd1, 1'b1, 32'h0000_5000, 8'd2, 3'd2}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = idx; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [31:0] d);
        cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = idx;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_sel = 1'b0;
    endtask

    // one peripheral transfer; optionally reads the address register in the ack cycle
    task automatic serve(input logic [31:0] din, input bit rd_at_ack);
        int t = 0;
        dev_rdata = din;
        dev_req = 1'b1;
        @(negedge clk);
        while (!mem_req && t < 20) begin
            @(negedge clk);
            t++;
        end
        s_seen = mem_req; s_addr = mem_addr; s_we = mem_we;
        s_size = mem_size; s_wd = mem_wdata;
        @(negedge clk);
        s_ack = dev_ack; s_dw = dev_wdata;
        dev_req = 1'b0;
        if (rd_at_ack) begin
            cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = 2'd0;
        end
        @(negedge clk);
        cpu_sel = 1'b0;
    endtask

    // hold a request for a few cycles and report whether any memory cycle appeared
    task automatic idle_probe(output logic seen);
        seen = 1'b0;
        dev_req = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (mem_req) seen = 1'b1;
        end
        dev_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd3, d); chk("R1 status", d, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 mem_req/dev_ack", {30'h0, mem_req, dev_ack}, 32'h0);
        rd(2'd2, d); chk("R1 command", d, 32'h0);

        // R12 status writes ignored
        wr(2'd3, 32'h0000_00FF);
        rd(2'd3, d); chk("R12 status write ignored", d, 32'h0);

        // R5 go without enable, enable without go
        wr(2'd0, 32'h0000_0100); wr(2'd1, 32'h0);
        wr(2'd2, 32'h0000_8000);
        rd(2'd3, d); chk("R5 go without enable", d, 32'h0);
        idle_probe(seen); chk("R5 no cycle without enable", {31'h0, seen}, 32'h0);
        wr(2'd2, 32'h0000_0001);
        rd(2'd3, d); chk("R5 enable without go", d, 32'h0);

        // R11 priority and level readback
        wr(2'd2, 32'h0000_0058);
        rd(2'd2, d); chk("R11 command readback", d, 32'h0000_0058);
        chk("R11 irq_level 8", {28'h0, irq_level}, 32'h8);
        wr(2'd2, 32'h0000_0000);
        chk("R11 irq_level 3", {28'h0, irq_level}, 32'h3);

        // R12 accessed bit and write blocking while armed; R7 set beats read-clear
        wr(2'd0, 32'h0000_0100); wr(2'd1, 32'h0);
        wr(2'd2, 32'h0000_8001);
        rd(2'd3, d); chk("R12 armed status", d, 32'h0000_0005);
        wr(2'd0, 32'h0000_0999);
        wr(2'd2, 32'h0000_0102);
        rd(2'd2, d); chk("R12 command write blocked", d, 32'h0000_0001);
        serve(32'h0000_00AA, 1'b1);
        chk("R12 address write blocked", s_addr, 32'h0000_0100);
        chk("R7 set wins over read-clear irq", {31'h0, irq}, 32'h1);
        rd(2'd3, d); chk("R7 set wins status", d, 32'h0000_0042);
        rd(2'd0, d);
        chk("R7 read clears irq", {31'h0, irq}, 32'h0);

        // R8 misaligned starts
        wr(2'd0, 32'h0000_1002); wr(2'd1, 32'h3);
        wr(2'd2, 32'h0000_8101);
        rd(2'd3, d); chk("R8 long misaligned status", d, 32'h0000_0028);
        idle_probe(seen); chk("R8 no memory cycle", {31'h0, seen}, 32'h0);
        wr(2'd0, 32'h0000_1001);
        wr(2'd2, 32'h0000_8003);
        rd(2'd3, d); chk("R8 word misaligned status", d, 32'h0000_0028);

        // R9 bus error on the third longword
        bad_addr = 32'h0000_6008;
        wr(2'd0, 32'h0000_6000); wr(2'd1, 32'h3);
        wr(2'd2, 32'h0000_8101);
        serve(32'h1, 1'b0); chk("R9 first cycle acked", {31'h0, s_ack}, 32'h1);
        serve(32'h2, 1'b0); chk("R9 second cycle acked", {31'h0, s_ack}, 32'h1);
        serve(32'h3, 1'b0);
        chk("R9 failing cycle issued", {31'h0, s_seen}, 32'h1);
        chk("R9 no ack on error", {31'h0, s_ack}, 32'h0);
        rd(2'd3, d); chk("R9 status", d, 32'h0000_001A);
        chk("R9 irq", {31'h0, irq}, 32'h1);
        rd(2'd0, d); chk("R9 address held", d, 32'h0000_6008);
        bad_addr = 32'hFFFF_FFF0;

        // table of transfers: R2 R3 R4 R6 R7
        for (int i = 0; i < 6; i++) begin
            logic [45:0] v;
            logic [31:0] base, e_addr;
            logic [7:0]  n;
            logic [2:0]  st;
            logic [1:0]  e_size;
            v = VEC[i];
            base = v[42:11]; n = v[10:3]; st = v[2:0];
            e_size = v[45] ? 2'd2 : (v[44] ? 2'd1 : 2'd0);
            wr(2'd0, base);
            wr(2'd1, 32'(n) - 32'd1);
            wr(2'd2, {16'h0, 7'h0, v[45], 4'h8, 1'b0, v[43], v[44], 1'b1} | 32'h0000_8000);
            for (int k = 0; k < int'(n); k++) begin
                e_addr = base + 32'(k) * 32'(st);
                serve(32'hC000_0000 + 32'(k), 1'b0);
                chk($sformatf("R2 cycle %0d/%0d seen", i, k), {31'h0, s_seen}, 32'h1);
                chk($sformatf("R3 address %0d/%0d", i, k), s_addr, e_addr);
                chk($sformatf("R3 size %0d/%0d", i, k), {30'h0, s_size}, {30'h0, e_size});
                chk($sformatf("R10 ack %0d/%0d", i, k), {31'h0, s_ack}, 32'h1);
                chk($sformatf("R4 write enable %0d/%0d", i, k), {31'h0, s_we}, {31'h0, !v[43]});
                if (v[43])
                    chk($sformatf("R4 device data %0d/%0d", i, k), s_dw, e_addr ^ 32'h5A5A_0000);
                else
                    chk($sformatf("R4 memory data %0d/%0d", i, k), s_wd, 32'hC000_0000 + 32'(k));
            end
            idle_probe(seen); chk($sformatf("R2 no extra cycle %0d", i), {31'h0, seen}, 32'h0);
            rd(2'd3, d); chk($sformatf("R6 status %0d", i), d, 32'h0000_0042);
            chk($sformatf("R6 irq %0d", i), {31'h0, irq}, 32'h1);
            rd(2'd1, d); chk($sformatf("R6 count wrapped %0d", i), d, 32'hFFFF_FFFF);
            rd(2'd0, d); chk($sformatf("R3 end address %0d", i), d, base + 32'(n) * 32'(st));
            chk($sformatf("R7 irq cleared %0d", i), {31'h0, irq}, 32'h0);
            rd(2'd3, d); chk($sformatf("R7 status after clear %0d", i), d, 32'h0000_0040);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule